// File: doc/BRIEF.md
# Multi-Mode Dual-Clock Transmit FIFO

This block sits between a core logic clock domain (the write side) and a transmit PCS clock domain (the read side). It holds up to 32 words and works in one of three behaviours, chosen by a static `mode` input.

In elastic mode, a word is stored only when `wr_valid` is high, and a word is popped only when the downstream framer raises `rd_req`. The write clock may run faster than the read clock. In phase-compensation mode, the write side stores one entry on every write clock, with its valid bit attached. The read side drains continuously, so the FIFO only absorbs a fixed phase offset between two clocks of equal frequency. In bypass mode, the storage is left idle: data and valid are captured by one register stage on the read clock.

Both pointers cross between domains as gray codes, through two-flop synchronisers. The write domain works out occupancy from its own pointer and the synchronised read pointer. From that occupancy it produces four registered flags, each compared against its own 5-bit threshold input. Errors are sticky: a write into a full FIFO sets a bit in the write domain, and a request on an empty FIFO sets a bit in the read domain.

Top module: `txf_multimode`

## Requirements
- R1: The `mode` encoding is 2'd0 elastic, 2'd1 phase compensation, and 2'd2 or 2'd3 bypass. In elastic mode, a word is stored only on a write clock with `wr_valid`=1. A stored word is delivered only in answer to `rd_req`=1, and it appears on `rd_data` with `rd_valid`=1 just after the same read clock edge that samples the request. Words come out in write order.
- R2: The FIFO holds 32 entries. A write attempt while 32 entries are held is dropped, and it sets `ovf_err`. `ovf_err` then stays high until `wr_rst`.
- R3: An `rd_req` in elastic mode while the read side sees no entries produces no word (`rd_valid`=0). It sets `unf_err`, which stays high until `rd_rst`.
- R4: Occupancy is words written minus words read, as seen by the write domain. `flag_full` is high when occupancy >= `thr_full`, and `flag_pfull` is high when occupancy >= `thr_pfull`.
- R5: `flag_empty` is high when occupancy <= `thr_empty`, and `flag_pempty` is high when occupancy <= `thr_pempty`. All four flags are registered on `wr_clk`. They settle within a few clocks of both domains once activity stops.
- R6: In phase mode, the write side stores {`wr_valid`,`wr_data`} on every write clock. The read side pops whenever it is not empty and presents the stored valid bit on `rd_valid`. Valid words come out in order, and neither error bit is set while the clocks are equal.
- R7: In bypass mode, `rd_data` and `rd_valid` equal `wr_data` and `wr_valid` registered on `rd_clk`. Neither pointer moves, so `flag_empty` stays high with the default thresholds.
- R8: After reset, `rd_valid`=0, `ovf_err`=0, `unf_err`=0, occupancy is 0, `flag_empty`=1 and `flag_full`=0 (with `thr_full`=31 and `thr_empty`=0).
- R9: Each gray pointer changes by at most one bit per clock of its own domain.
- R10: With `FULL_PORT_EN`=1 (the default), `full_out` equals `flag_full`. With `FULL_PORT_EN`=0 it is tied low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Core write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| rd_clk | input | 1 | PCS read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| mode | input | 2 | Behaviour select (0 elastic, 1 phase, 2/3 bypass), static out of reset |
| wr_data | input | DATA_W | Write data |
| wr_valid | input | 1 | Write data valid |
| rd_req | input | 1 | Framer read request (elastic mode) |
| thr_full | input | ADDR_W | Full threshold (0..31) |
| thr_empty | input | ADDR_W | Empty threshold (0..31) |
| thr_pfull | input | ADDR_W | Partially-full threshold (0..31) |
| thr_pempty | input | ADDR_W | Partially-empty threshold (0..31) |
| rd_data | output | DATA_W | Read data |
| rd_valid | output | 1 | Read data valid |
| flag_full | output | 1 | Occupancy >= thr_full, write domain |
| flag_empty | output | 1 | Occupancy <= thr_empty, write domain |
| flag_pfull | output | 1 | Occupancy >= thr_pfull, write domain |
| flag_pempty | output | 1 | Occupancy <= thr_pempty, write domain |
| full_out | output | 1 | Optional full port, write domain |
| ovf_err | output | 1 | Sticky overflow error, write domain |
| unf_err | output | 1 | Sticky underflow error, read domain |

## Verification
Suppose a pointer is wrong or a synchroniser is dropped. That shows up at the ports in two ways. The write-side flags disagree with the known occupancy a few clocks after activity stops. The word stream on `rd_data` loses, repeats or reorders entries, and that is seen on the first read clock where the bad word leaves. A wrong full or empty decision shows up at the 32-entry and 0-entry boundaries as a missing or spurious error bit, or as an extra or missing `rd_valid`. A wrong mode decode shows up within one read clock as data that is not registered straight through, or as valid words missing in phase mode.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    TXF_ELASTIC = 2'd0,
    TXF_PHASE   = 2'd1,
    TXF_BYPASS  = 2'd2
  } txf_mode_e;
endpackage

// File: rtl/txf_sync2.sv
// Two-flop synchroniser for a gray-coded bus.
module txf_sync2 #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/txf_ram.sv
// Simple dual-port storage with a registered read, written for block RAM inference.
module txf_ram #(
  parameter int DW = 33,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/txf_wr_side.sv
// Write pointer, occupancy, threshold flags and overflow detection.
module txf_wr_side
  import txf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          wr_valid,
  input  logic [AW:0]   rptr_gray_s,
  input  logic [AW-1:0] thr_full,
  input  logic [AW-1:0] thr_empty,
  input  logic [AW-1:0] thr_pfull,
  input  logic [AW-1:0] thr_pempty,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wptr_gray,
  output logic          flag_full,
  output logic          flag_empty,
  output logic          flag_pfull,
  output logic          flag_pempty,
  output logic          ovf_err
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b = g;
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin, wbin_nx, rbin, occ;
  logic          req, at_cap;

  always_comb begin
    rbin    = g2b(rptr_gray_s);
    occ     = wbin - rbin;
    at_cap  = (occ == CAP);
    req     = (mode == TXF_ELASTIC) ? wr_valid : (mode == TXF_PHASE);
    wr_en   = req && !at_cap;
    wbin_nx = wbin + PW'(wr_en);
    waddr   = wbin[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin      <= '0;
      wptr_gray <= '0;
      ovf_err   <= 1'b0;
    end else begin
      wbin      <= wbin_nx;
      wptr_gray <= wbin_nx ^ (wbin_nx >> 1);
      ovf_err   <= ovf_err | (req & at_cap);
    end
  end

  // Flags follow the occupancy of the previous cycle, so they need no reset branch.
  always_ff @(posedge clk) begin
    flag_full   <= occ >= {1'b0, thr_full};
    flag_pfull  <= occ >= {1'b0, thr_pfull};
    flag_empty  <= occ <= {1'b0, thr_empty};
    flag_pempty <= occ <= {1'b0, thr_pempty};
  end
endmodule

// File: rtl/txf_rd_side.sv
// Read pointer, empty detection and underflow detection.
module txf_rd_side
  import txf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          rd_req,
  input  logic [AW:0]   wptr_gray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rptr_gray,
  output logic          fire_q,
  output logic          unf_err
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nx;
  logic          empty, req;

  always_comb begin
    empty   = (rptr_gray == wptr_gray_s);
    req     = (mode == TXF_ELASTIC) ? rd_req : (mode == TXF_PHASE);
    re      = req && !empty;
    rbin_nx = rbin + PW'(re);
    raddr   = rbin[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin      <= '0;
      rptr_gray <= '0;
      fire_q    <= 1'b0;
      unf_err   <= 1'b0;
    end else begin
      rbin      <= rbin_nx;
      rptr_gray <= rbin_nx ^ (rbin_nx >> 1);
      fire_q    <= re;
      unf_err   <= unf_err | ((mode == TXF_ELASTIC) & rd_req & empty);
    end
  end
endmodule

// File: rtl/txf_multimode.sv
module txf_multimode
  import txf_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 5,
  parameter bit FULL_PORT_EN = 1'b1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] thr_full,
  input  logic [ADDR_W-1:0] thr_empty,
  input  logic [ADDR_W-1:0] thr_pfull,
  input  logic [ADDR_W-1:0] thr_pempty,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              flag_full,
  output logic              flag_empty,
  output logic              flag_pfull,
  output logic              flag_pempty,
  output logic              full_out,
  output logic              ovf_err,
  output logic              unf_err
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int ENT_W = DATA_W + 1;

  logic [PTR_W-1:0]  wptr_gray, rptr_gray, wptr_gray_s, rptr_gray_s;
  logic              wr_en, re, fire_q;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ENT_W-1:0]  ram_q;
  logic [DATA_W-1:0] byp_data;
  logic              byp_valid, bypass;

  assign bypass = (mode != TXF_ELASTIC) && (mode != TXF_PHASE);

  txf_sync2 #(.W(PTR_W)) u_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rptr_gray), .q(rptr_gray_s)
  );

  txf_sync2 #(.W(PTR_W)) u_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wptr_gray), .q(wptr_gray_s)
  );

  txf_wr_side #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .mode(mode), .wr_valid(wr_valid),
    .rptr_gray_s(rptr_gray_s),
    .thr_full(thr_full), .thr_empty(thr_empty),
    .thr_pfull(thr_pfull), .thr_pempty(thr_pempty),
    .wr_en(wr_en), .waddr(waddr), .wptr_gray(wptr_gray),
    .flag_full(flag_full), .flag_empty(flag_empty),
    .flag_pfull(flag_pfull), .flag_pempty(flag_pempty),
    .ovf_err(ovf_err)
  );

  txf_rd_side #(.AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .mode(mode), .rd_req(rd_req),
    .wptr_gray_s(wptr_gray_s), .re(re), .raddr(raddr),
    .rptr_gray(rptr_gray), .fire_q(fire_q), .unf_err(unf_err)
  );

  txf_ram #(.DW(ENT_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(wr_en), .waddr(waddr), .wdata({wr_valid, wr_data}),
    .rclk(rd_clk), .re(re), .raddr(raddr), .rdata(ram_q)
  );

  // Bypass path: one register stage on the read clock.
  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      byp_data  <= '0;
      byp_valid <= 1'b0;
    end else begin
      byp_data  <= wr_data;
      byp_valid <= wr_valid;
    end
  end

  assign rd_data  = bypass ? byp_data  : ram_q[DATA_W-1:0];
  assign rd_valid = bypass ? byp_valid : (fire_q & ram_q[DATA_W]);

  generate
    if (FULL_PORT_EN) begin : g_full_port
      assign full_out = flag_full;
    end else begin : g_no_full_port
      assign full_out = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/txf_multimode_chk.sv
module txf_multimode_chk #(
  parameter int PW = 6
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic [1:0]    mode,
  input logic          wr_valid,
  input logic          rd_req,
  input logic          rd_valid,
  input logic          ovf_err,
  input logic          unf_err,
  input logic [PW-1:0] wptr_gray,
  input logic [PW-1:0] rptr_gray
);
  assert_elastic_valid_needs_req_R1: assert property (
    @(posedge rd_clk) disable iff (rd_rst)
    (mode == 2'd0 && rd_valid) |-> $past(rd_req));

  assert_ovf_sticky_R2: assert property (
    @(posedge wr_clk) disable iff (wr_rst) ovf_err |=> ovf_err);

  assert_unf_sticky_R3: assert property (
    @(posedge rd_clk) disable iff (rd_rst) unf_err |=> unf_err);

  assert_bypass_registered_R7: assert property (
    @(posedge rd_clk) disable iff (rd_rst)
    (mode[1] && $past(mode[1])) |-> (rd_valid == $past(wr_valid)));

  assert_wptr_gray_step_R9: assert property (
    @(posedge wr_clk) disable iff (wr_rst)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  assert_rptr_gray_step_R9: assert property (
    @(posedge rd_clk) disable iff (rd_rst)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);
endmodule

bind txf_multimode txf_multimode_chk #(.PW(PTR_W)) i_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
  .mode(mode), .wr_valid(wr_valid), .rd_req(rd_req), .rd_valid(rd_valid),
  .ovf_err(ovf_err), .unf_err(unf_err),
  .wptr_gray(wptr_gray), .rptr_gray(rptr_gray)
);

// File: tb/test_txf_multimode.sv
module test_txf_multimode;
  localparam int WR_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst = 1'b1, rd_rst = 1'b1;
  logic [1:0]    mode = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_valid = 1'b0, rd_req = 1'b0;
  logic [AW-1:0] thr_full = 5'd31, thr_empty = 5'd0, thr_pfull = 5'd23, thr_pempty = 5'd4;
  logic [DW-1:0] rd_data;
  logic          rd_valid, flag_full, flag_empty, flag_pfull, flag_pempty;
  logic          full_out, ovf_err, unf_err;

  int rd_half = 7;
  int errors = 0, checks = 0, model_cnt = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] next_val = 32'hA500_0001;
  bit mon_en = 1'b0, done = 1'b0;
  string mon_tag = "R1";

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  txf_multimode #(.DATA_W(DW), .ADDR_W(AW)) i_txf_multimode (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .mode(mode), .wr_data(wr_data), .wr_valid(wr_valid), .rd_req(rd_req),
    .thr_full(thr_full), .thr_empty(thr_empty), .thr_pfull(thr_pfull), .thr_pempty(thr_pempty),
    .rd_data(rd_data), .rd_valid(rd_valid), .flag_full(flag_full), .flag_empty(flag_empty),
    .flag_pfull(flag_pfull), .flag_pempty(flag_pempty), .full_out(full_out),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Reference comparison on every read clock: each valid word must be the oldest expected one.
  always @(negedge rd_clk) begin
    if (mon_en && !rd_rst && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, {mon_tag, " unexpected word"}, rd_data, '0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, {mon_tag, " word order"}, rd_data, e);
      end
    end
  end

  task automatic do_reset(input logic [1:0] m);
    mode = m; wr_valid = 1'b0; rd_req = 1'b0;
    wr_rst = 1'b1; rd_rst = 1'b1;
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    exp_q.delete(); model_cnt = 0;
    wr_rst = 1'b0; rd_rst = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic check_flags(input string tag);
    settle();
    chk(flag_full   == (model_cnt >= int'(thr_full)),   {tag, " R4 flag_full"},   DW'(flag_full),   DW'(model_cnt >= int'(thr_full)));
    chk(flag_pfull  == (model_cnt >= int'(thr_pfull)),  {tag, " R4 flag_pfull"},  DW'(flag_pfull),  DW'(model_cnt >= int'(thr_pfull)));
    chk(flag_empty  == (model_cnt <= int'(thr_empty)),  {tag, " R5 flag_empty"},  DW'(flag_empty),  DW'(model_cnt <= int'(thr_empty)));
    chk(flag_pempty == (model_cnt <= int'(thr_pempty)), {tag, " R5 flag_pempty"}, DW'(flag_pempty), DW'(model_cnt <= int'(thr_pempty)));
    chk(full_out == flag_full, {tag, " R10 full_out"}, DW'(full_out), DW'(flag_full));
  endtask

  task automatic push_words(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_valid = 1'b1; wr_data = next_val;
      if (model_cnt < DEPTH) begin exp_q.push_back(next_val); model_cnt++; end
      next_val = next_val + 32'h0101_0107;
      if (gaps && (i % 3 == 1)) begin
        @(negedge wr_clk);
        wr_valid = 1'b0;
      end
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic pull_words(input int n, input bit gaps, input string tag);
    bit pend_v = 1'b0, have_pend = 1'b0;
    int issued = 0, k = 0;
    while (issued < n || have_pend) begin
      @(negedge rd_clk);
      if (have_pend) chk(rd_valid == pend_v, {tag, " rd_valid"}, DW'(rd_valid), DW'(pend_v));
      have_pend = 1'b0; rd_req = 1'b0;
      if (issued < n) begin
        if (gaps && (k % 4 == 3)) begin
          pend_v = 1'b0; have_pend = 1'b1;
        end else begin
          rd_req = 1'b1; pend_v = (model_cnt > 0);
          if (pend_v) model_cnt--;
          issued++; have_pend = 1'b1;
        end
        k++;
      end
    end
    rd_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R8 watchdog act=hung exp=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Elastic mode, write clock faster than read clock.
    do_reset(2'd0);
    mon_en = 1'b1; mon_tag = "R1";
    settle();
    chk(rd_valid == 1'b0, "R8 rd_valid after reset", DW'(rd_valid), '0);
    chk(ovf_err == 1'b0, "R8 ovf_err after reset", DW'(ovf_err), '0);
    chk(unf_err == 1'b0, "R8 unf_err after reset", DW'(unf_err), '0);
    check_flags("R8 reset");

    push_words(10, 1'b1);
    check_flags("R4 occ10");
    pull_words(4, 1'b1, "R1 elastic read");
    check_flags("R5 occ6");

    // Threshold boundaries at occupancy 6.
    thr_pfull = 5'd6; thr_pempty = 5'd6; thr_empty = 5'd5; thr_full = 5'd7;
    check_flags("R4 R5 equal thresholds");
    thr_pfull = 5'd7; thr_pempty = 5'd5; thr_empty = 5'd6; thr_full = 5'd6;
    check_flags("R4 R5 off-by-one thresholds");
    thr_full = 5'd31; thr_empty = 5'd0; thr_pfull = 5'd23; thr_pempty = 5'd4;

    // Fill to capacity, then overflow.
    push_words(26, 1'b0);
    settle();
    chk(ovf_err == 1'b0, "R2 no overflow at 32", DW'(ovf_err), '0);
    check_flags("R4 occ32");
    push_words(3, 1'b0);
    settle();
    chk(ovf_err == 1'b1, "R2 overflow sticky set", DW'(ovf_err), 32'd1);

    // Drain everything and two more requests.
    pull_words(34, 1'b0, "R2 R3 drain");
    settle();
    chk(unf_err == 1'b1, "R3 underflow set", DW'(unf_err), 32'd1);
    chk(DW'(exp_q.size()) == '0, "R2 all stored words delivered", DW'(exp_q.size()), '0);
    chk(ovf_err == 1'b1, "R2 overflow still held", DW'(ovf_err), 32'd1);
    check_flags("R5 drained");
    do_reset(2'd0);
    settle();
    chk(ovf_err == 1'b0, "R2 overflow cleared by reset", DW'(ovf_err), '0);
    chk(unf_err == 1'b0, "R3 underflow cleared by reset", DW'(unf_err), '0);

    // Phase-compensation mode with equal clocks.
    rd_half = WR_PERIOD / 2;
    do_reset(2'd1);
    mon_tag = "R6";
    for (int i = 0; i < 60; i++) begin
      @(negedge wr_clk);
      wr_data = next_val; wr_valid = (i % 3 != 0);
      if (wr_valid) exp_q.push_back(next_val);
      next_val = next_val + 32'h0003_0011;
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
    repeat (20) @(negedge wr_clk);
    settle();
    chk(DW'(exp_q.size()) == '0, "R6 valid words all delivered", DW'(exp_q.size()), '0);
    chk(ovf_err == 1'b0, "R6 no overflow", DW'(ovf_err), '0);
    chk(unf_err == 1'b0, "R6 no underflow", DW'(unf_err), '0);

    // Bypass mode.
    mon_en = 1'b0;
    do_reset(2'd2);
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] d;
      logic v;
      d = 32'h5A00_0000 + DW'(i * 37); v = i[0];
      @(negedge rd_clk);
      wr_data = d; wr_valid = v;
      @(negedge rd_clk);
      chk(rd_data == d, "R7 bypass data", rd_data, d);
      chk(rd_valid == v, "R7 bypass valid", DW'(rd_valid), DW'(v));
    end
    wr_valid = 1'b0;
    model_cnt = 0;
    check_flags("R7 bypass leaves storage empty");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule